// File: doc/BRIEF.md
# Serial Command/Data Framing Receiver

This block is the write-only front end of a display controller's 4-wire serial port. While the active-low select is asserted, it shifts one bit in on each rising edge of the serial clock, most significant bit first. Every eighth edge completes a byte. That byte is reported as a one-cycle pulse tagged as either a command or display data. Each display data byte also produces a strobe that advances the column address. The block does not execute commands and does not hold display memory.

The block classifies bytes in one of two ways. In pin mode, a register-select input decides the tag of each byte. In in-band mode, every byte is a command unless a two-byte header has opened a counted data run. The header is a direction opcode followed by a count byte. The run holds N bytes, and when it has been used up the receiver goes back to commands. The serial inputs are asynchronous to the system clock. They are synchronised and edge-detected inside the block, and all state runs on the system clock.

Top module: `serial_frame_rx`

## Requirements
- R1: While `cs_n` is high, the bit counter and the shift register are cleared. A partly shifted byte is discarded, and the first byte after reselection starts from a fresh bit count.
- R2: `sdin` is sampled on each rising edge of `sclk` while selected. The first bit sampled becomes bit 7 of the byte.
- R3: The eighth rising `sclk` edge produces a single-cycle `out_vld` carrying the byte on `out_byte`. The pulse appears after the fourth rising `clk` edge after `sclk` goes high.
- R4: With `rs_en` = 1, a byte is data (`out_is_data` = 1) when `rs` is 1 and a command when `rs` is 0.
- R5: With `rs_en` = 0, a byte is a command (`out_is_data` = 0) unless a data run is open.
- R6: With `rs_en` = 0, the direction opcode 0xE8 followed directly by a count byte (bit 7 = 0, N = bits 6..0) makes the next N bytes data. Both header bytes are reported as commands.
- R7: `col_inc` pulses together with `out_vld` for each data byte and never for a command, in both modes.
- R8: Once N data bytes have been received, the next byte is a command. N = 0 opens no run.
- R9: A byte with bit 7 = 1 that arrives directly after 0xE8 cancels the header and is processed as an ordinary command. If that byte is 0xE8 itself, it arms a new header.
- R10: The remaining run length survives `cs_n` being raised and lowered again.
- R11: `sclk` edges while `cs_n` is high produce no byte.
- R12: During and directly after reset, `out_vld`, `out_is_data`, `col_inc` and `out_byte` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select (asynchronous) |
| sclk | input | 1 | Serial clock (asynchronous) |
| sdin | input | 1 | Serial data, MSB first |
| rs | input | 1 | Register select: 1 = data, 0 = command (pin mode) |
| rs_en | input | 1 | 1 = pin mode, 0 = in-band header mode |
| out_vld | output | 1 | One-cycle pulse per received byte |
| out_byte | output | 8 | Received byte |
| out_is_data | output | 1 | Tag of the byte: 1 = data, 0 = command |
| col_inc | output | 1 | Column address advance strobe |

## Verification
A rising `sclk` passes through two synchroniser flops and then the shift stage, and the tag is added by the classifier register. The byte result is therefore due after the fourth rising `clk` edge following the change on `sclk`. One directed test holds the eighth bit and samples `out_vld` at each of the five falling edges that follow. It requires a pulse only at the fourth. All other results are collected by a monitor that samples at falling clock edges. It stores every pulse in order, and each scenario waits several idle cycles past that latency before comparing the number of bytes and each byte's value and tags.

// File: rtl/serial_frame_rx_pkg.sv
package serial_frame_rx_pkg;

    localparam int BYTE_W    = 8;
    localparam int BITCNT_W  = $clog2(BYTE_W);

    typedef logic [BYTE_W-1:0] byte_t;

    // byte leaving the shift stage
    typedef struct packed {
        logic  vld;
        byte_t data;
    } rx_byte_t;

    // tagged byte leaving the classifier
    typedef struct packed {
        logic  vld;
        logic  is_data;
        byte_t data;
    } frame_t;

    typedef enum logic {
        HDR_IDLE     = 1'b0,
        HDR_WAIT_CNT = 1'b1
    } hdr_state_e;

    // a count byte has its top bit clear
    function automatic logic is_count_byte(input byte_t b);
        return ~b[BYTE_W-1];
    endfunction

endpackage

// File: rtl/sfr_sync.sv
module sfr_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage[i] <= RST_VAL;
                else     stage[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage[i] <= RST_VAL;
                else     stage[i] <= stage[i-1];
            end
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/sfr_shift.sv
module sfr_shift
    import serial_frame_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cs_n,
    input  logic     sclk,
    input  logic     sdin,
    output rx_byte_t rx
);
    logic                sclk_q;
    logic [BITCNT_W-1:0] bit_cnt;
    logic [BYTE_W-2:0]   shreg;
    logic                rise;

    assign rise = sclk & ~sclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q  <= 1'b0;
            bit_cnt <= '0;
            shreg   <= '0;
            rx      <= '0;
        end else begin
            sclk_q <= sclk;
            rx.vld <= 1'b0;
            if (cs_n) begin
                bit_cnt <= '0;
                shreg   <= '0;
            end else if (rise) begin
                shreg <= {shreg[BYTE_W-3:0], sdin};
                if (bit_cnt == BITCNT_W'(BYTE_W-1)) begin
                    rx.vld  <= 1'b1;
                    rx.data <= {shreg, sdin};
                    bit_cnt <= '0;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    // R11: no byte can complete while deselected
    assert_no_byte_deselected_R11: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> !rx.vld);

    // R3: a byte only completes on a detected serial clock rise
    assert_byte_on_rise_R3: assert property (@(posedge clk) disable iff (rst)
        rx.vld |-> $past(sclk && !sclk_q && !cs_n));

    // R1: deselection leaves the bit counter at zero
    assert_deselect_clears_R1: assert property (@(posedge clk) disable iff (rst)
        $past(cs_n) |-> bit_cnt == '0);
endmodule

// File: rtl/sfr_classify.sv
module sfr_classify
    import serial_frame_rx_pkg::*;
#(
    parameter int    RUN_W  = 7,
    parameter byte_t DIR_OP = 8'hE8
) (
    input  logic     clk,
    input  logic     rst,
    input  rx_byte_t rx,
    input  logic     rs,
    input  logic     rs_en,
    output frame_t   fr,
    output logic     col_inc
);
    hdr_state_e       state, state_n;
    logic [RUN_W-1:0] remain, remain_n;
    logic             is_data_c;

    always_comb begin
        state_n   = state;
        remain_n  = remain;
        is_data_c = 1'b0;
        if (rx.vld) begin
            if (rs_en) begin
                is_data_c = rs;
            end else if (remain != '0) begin
                is_data_c = 1'b1;
                remain_n  = remain - 1'b1;
            end else if (state == HDR_WAIT_CNT && is_count_byte(rx.data)) begin
                remain_n = rx.data[RUN_W-1:0];
                state_n  = HDR_IDLE;
            end else begin
                state_n = (rx.data == DIR_OP) ? HDR_WAIT_CNT : HDR_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= HDR_IDLE;
            remain  <= '0;
            fr      <= '0;
            col_inc <= 1'b0;
        end else begin
            state      <= state_n;
            remain     <= remain_n;
            fr.vld     <= rx.vld;
            fr.is_data <= rx.vld & is_data_c;
            col_inc    <= rx.vld & is_data_c;
            if (rx.vld) fr.data <= rx.data;
        end
    end

    // R4: in pin mode the tag follows the select pin
    assert_pin_select_R4: assert property (@(posedge clk) disable iff (rst)
        (rx.vld && rs_en) |=> (fr.vld && fr.is_data == $past(rs)));

    // R7: the column strobe only accompanies data bytes
    assert_col_inc_data_R7: assert property (@(posedge clk) disable iff (rst)
        col_inc |-> (fr.vld && fr.is_data));

    // R6: each byte of an open run is data and consumes one count
    assert_run_consume_R6: assert property (@(posedge clk) disable iff (rst)
        (rx.vld && !rs_en && remain != '0) |=>
            (fr.is_data && remain == RUN_W'($past(remain) - 1'b1)));

    // R5: with no open run, in-band bytes are commands
    assert_default_cmd_R5: assert property (@(posedge clk) disable iff (rst)
        (rx.vld && !rs_en && remain == '0) |=> !fr.is_data);

    // R10: the run length only moves when a byte arrives
    assert_remain_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !rx.vld |=> $stable(remain));
endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
    import serial_frame_rx_pkg::*;
#(
    parameter int    SYNC_STAGES = 2,
    parameter int    RUN_W       = 7,
    parameter byte_t DIR_OP      = 8'hE8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cs_n,
    input  logic        sclk,
    input  logic        sdin,
    input  logic        rs,
    input  logic        rs_en,
    output logic        out_vld,
    output logic [7:0]  out_byte,
    output logic        out_is_data,
    output logic        col_inc
);
    localparam int NSYNC = 5;

    logic [NSYNC-1:0] raw, synced;
    rx_byte_t         rx;
    frame_t           fr;

    assign raw = {cs_n, sclk, sdin, rs, rs_en};

    sfr_sync #(
        .W       (NSYNC),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (5'b10000)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (synced)
    );

    sfr_shift u_shift (
        .clk  (clk),
        .rst  (rst),
        .cs_n (synced[4]),
        .sclk (synced[3]),
        .sdin (synced[2]),
        .rx   (rx)
    );

    sfr_classify #(
        .RUN_W  (RUN_W),
        .DIR_OP (DIR_OP)
    ) u_class (
        .clk     (clk),
        .rst     (rst),
        .rx      (rx),
        .rs      (synced[1]),
        .rs_en   (synced[0]),
        .fr      (fr),
        .col_inc (col_inc)
    );

    assign out_vld     = fr.vld;
    assign out_byte    = fr.data;
    assign out_is_data = fr.is_data;

    // R12: outputs are quiet in the cycle after reset
    assert_reset_quiet_R12: assert property (@(posedge clk)
        $past(rst) |-> (!out_vld && !col_inc && !out_is_data));
endmodule

// File: tb/serial_frame_rx_bench.sv
`timescale 1ns/1ps
module serial_frame_rx_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, sclk = 1'b0, sdin = 1'b0, rs = 1'b0, rs_en = 1'b0;
    logic       out_vld, out_is_data, col_inc;
    logic [7:0] out_byte;

    int total = 0;
    int bad   = 0;
    int n_got = 0;
    logic [7:0] got_b [0:255];
    logic       got_d [0:255];
    logic       got_c [0:255];
    bit         finished = 0;

    always #5 clk = ~clk;

    serial_frame_rx u_serial_frame_rx (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdin(sdin),
        .rs(rs), .rs_en(rs_en), .out_vld(out_vld), .out_byte(out_byte),
        .out_is_data(out_is_data), .col_inc(col_inc)
    );

    always @(negedge clk) begin
        if (!rst && out_vld && n_got < 256) begin
            got_b[n_got] = out_byte;
            got_d[n_got] = out_is_data;
            got_c[n_got] = col_inc;
            n_got++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic exp_byte(input int idx, input int b, input int d, input string req);
        chk(req, got_b[idx], b);
        chk(req, got_d[idx], d);
        chk(req, got_c[idx], d);
    endtask

    task automatic send_bit(input logic v);
        @(negedge clk); sdin = v; sclk = 1'b0;
        repeat (2) @(negedge clk);
        sclk = 1'b1;
        repeat (3) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
    endtask

    task automatic settle();
        repeat (10) @(negedge clk);
    endtask

    task automatic select(input logic v);
        @(negedge clk); cs_n = v;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R12 vld in reset", out_vld, 0);
        chk("R12 byte in reset", out_byte, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R12 vld after reset", out_vld, 0);
        chk("R12 tag after reset", out_is_data, 0);
        chk("R12 col_inc after reset", col_inc, 0);
    endtask

    task automatic t_pin_mode();
        int n0;
        rs_en = 1'b1; rs = 1'b1;
        select(1'b0);
        n0 = n_got;
        send_byte(8'hA5);
        settle();
        rs = 1'b0;
        repeat (3) @(negedge clk);
        send_byte(8'h3C);
        settle();
        chk("R4 count", n_got - n0, 2);
        exp_byte(n0,   8'hA5, 1, "R2 R4 R7 data by pin");
        exp_byte(n0+1, 8'h3C, 0, "R4 R7 command by pin");
    endtask

    task automatic t_latency();
        for (int i = 7; i >= 1; i--) send_bit(i[0]);
        @(negedge clk); sdin = 1'b1; sclk = 1'b0;
        repeat (2) @(negedge clk);
        sclk = 1'b1;
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            chk($sformatf("R3 latency edge %0d", k), out_vld, (k == 4) ? 1 : 0);
        end
        sclk = 1'b0;
        settle();
        chk("R3 latency byte", got_b[n_got-1], 8'hAB);
    endtask

    task automatic t_default_cmd();
        int n0;
        rs_en = 1'b0; rs = 1'b1;
        repeat (4) @(negedge clk);
        n0 = n_got;
        send_byte(8'h12);
        send_byte(8'h34);
        settle();
        chk("R5 count", n_got - n0, 2);
        exp_byte(n0,   8'h12, 0, "R5 default command");
        exp_byte(n0+1, 8'h34, 0, "R5 default command");
    endtask

    task automatic t_run();
        int n0 = n_got;
        send_byte(8'hE8); send_byte(8'h03);
        send_byte(8'h01); send_byte(8'h02); send_byte(8'h03);
        send_byte(8'h77);
        settle();
        chk("R6 count", n_got - n0, 6);
        exp_byte(n0,   8'hE8, 0, "R6 opcode is command");
        exp_byte(n0+1, 8'h03, 0, "R6 count is command");
        exp_byte(n0+2, 8'h01, 1, "R6 R7 run data");
        exp_byte(n0+3, 8'h02, 1, "R6 R7 run data");
        exp_byte(n0+4, 8'h03, 1, "R6 R7 run data");
        exp_byte(n0+5, 8'h77, 0, "R8 after run");
    endtask

    task automatic t_zero();
        int n0 = n_got;
        send_byte(8'hE8); send_byte(8'h00); send_byte(8'h66);
        settle();
        chk("R8 zero count", n_got - n0, 3);
        exp_byte(n0+2, 8'h66, 0, "R8 N=0 no data");
    endtask

    task automatic t_cancel();
        int n0 = n_got;
        send_byte(8'hE8); send_byte(8'h9F); send_byte(8'h05);
        send_byte(8'hE8); send_byte(8'hE8); send_byte(8'h02);
        send_byte(8'hD1); send_byte(8'hD2); send_byte(8'h44);
        settle();
        chk("R9 count", n_got - n0, 9);
        exp_byte(n0+1, 8'h9F, 0, "R9 cancel byte is command");
        exp_byte(n0+2, 8'h05, 0, "R9 header cancelled");
        exp_byte(n0+4, 8'hE8, 0, "R9 re-arm opcode");
        exp_byte(n0+6, 8'hD1, 1, "R9 re-armed run");
        exp_byte(n0+7, 8'hD2, 1, "R9 re-armed run");
        exp_byte(n0+8, 8'h44, 0, "R9 R8 run end");
    endtask

    task automatic t_abort();
        int n0 = n_got;
        for (int i = 0; i < 5; i++) send_bit(1'b0);
        select(1'b1);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); sclk = 1'b1; sdin = i[0];
            repeat (3) @(negedge clk); sclk = 1'b0;
            repeat (3) @(negedge clk);
        end
        settle();
        chk("R11 no byte while deselected", n_got - n0, 0);
        select(1'b0);
        send_byte(8'hC3);
        settle();
        chk("R1 one byte after reselect", n_got - n0, 1);
        exp_byte(n0, 8'hC3, 0, "R1 partial byte discarded");
    endtask

    task automatic t_keep();
        int n0 = n_got;
        send_byte(8'hE8); send_byte(8'h04);
        send_byte(8'h11); send_byte(8'h22);
        select(1'b1);
        repeat (10) @(negedge clk);
        select(1'b0);
        send_byte(8'h33); send_byte(8'h44); send_byte(8'h55);
        settle();
        chk("R10 count", n_got - n0, 7);
        exp_byte(n0+4, 8'h33, 1, "R10 run kept across select");
        exp_byte(n0+5, 8'h44, 1, "R10 run kept across select");
        exp_byte(n0+6, 8'h55, 0, "R10 R8 run end");
    endtask

    initial begin
        t_reset();
        t_pin_mode();
        t_latency();
        t_default_cmd();
        t_run();
        t_zero();
        t_cancel();
        t_abort();
        t_keep();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule